// File: doc/BRIEF.md
# Packet Timestamp Capture with Single-Outstanding Lock

This block sits beside a free-running time counter in a network port. When a transmit event strobe, or a receive event strobe whose decoded message class passes the selected filter, arrives, the block copies the counter value into a per-direction capture register and sets that direction's valid flag. From then on the direction is locked: later events are dropped until software reads the upper capture word, which clears the flag and re-arms capture. This ties every stored timestamp to exactly one packet.

Software drives the block through a small word-wide register port. The port holds per-direction enables, a receive filter mode, a receive message-code configuration and an interrupt mask and cause. A transmit capture raises the interrupt cause when the mask allows it. Frame parsing happens upstream: receive events arrive with a class tag and a message code that are already decoded.

Top module: `pkt_stamp_latch`

## Requirements
- R1: A qualifying event strobe sampled at a clock edge stores the `time_i` value present at that edge into the direction's capture register, and the direction's valid flag reads 1 from the next cycle.
- R2: While a direction's valid flag is 1, further events in that direction are not captured, and the stored value stays unchanged.
- R3: A read of the upper capture word (address 5 for transmit, 7 for receive) clears that direction's valid flag at the following edge. A read of the lower word (address 4 or 6) leaves the flag set.
- R4: A direction whose enable bit (bit 0 of its control register) is 0 ignores its events.
- R5: Receive filter mode is RX control bits [3:2], and rx_class_i is coded 0 none, 1 version-1 over UDP, 2 version-2 event, 3 version-2 general. The modes are: mode 0 stamps class 1 whose rx_msg_i equals RX config bits [3:0]; mode 1 stamps class 1 whose rx_msg_i equals RX config bits [7:4]; mode 2 stamps class 2 only; mode 3 stamps every receive event.
- R6: A transmit capture sets the interrupt cause (IRQ register bit 0) only when the mask (IRQ register bit 1) is 1. irq_o equals the cause. Writing 1 to bit 0 clears the cause, and a capture in the same cycle as that write takes priority.
- R7: Writing a control register, whether to change the mode or to clear the enable, does not clear a pending valid flag or alter the stored value.
- R8: An event that arrives in the same cycle as the upper-word read that releases its direction is not captured, and the flag is 0 after that edge.
- R9: The register map is: 0 TX control (bit0 enable, bit1 valid, read-only); 1 RX control (bit0 enable, bit1 valid, bits[3:2] mode); 2 RX config; 3 IRQ; 4/5 TX low/high; 6/7 RX low/high. After reset every register reads 0 except RX config, which reads 0x10, and all valid flags and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_i | input | 64 | Running time counter value |
| tx_evt_i | input | 1 | Transmit timestamp event strobe |
| rx_evt_i | input | 1 | Receive timestamp event strobe |
| rx_class_i | input | 2 | Decoded receive message class |
| rx_msg_i | input | 4 | Decoded receive message code |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (upper-word reads release locks) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| tx_valid_o | output | 1 | Transmit capture valid flag |
| rx_valid_o | output | 1 | Receive capture valid flag |
| irq_o | output | 1 | Timestamp interrupt |

## Verification
Two functions can fall in the same cycle: a new event and the upper-word read that releases the lock, and a transmit capture and a write that clears the interrupt cause. The bench forces both collisions by raising the event strobe in the same cycle as the read or the write. A cycle-by-cycle behavioural model then judges the outcome: no capture and a cleared flag in the first case, a cause that stays set in the second. Control-register writes made while a capture is pending are also checked, by reading the stored words back afterwards.

// File: rtl/pkt_stamp_pkg.sv
// Shared types and register addresses for the packet timestamp capture block.
// Assumes a 3-bit register address space.
package pkt_stamp_pkg;
    typedef enum logic [1:0] {
        RXM_V1_SYNC = 2'd0,
        RXM_V1_DREQ = 2'd1,
        RXM_V2_EVT  = 2'd2,
        RXM_ALL     = 2'd3
    } rx_mode_e;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_V1_UDP = 2'd1,
        CLS_V2_EVT = 2'd2,
        CLS_V2_GEN = 2'd3
    } rx_class_e;

    localparam int A_TXCTL = 0;
    localparam int A_RXCTL = 1;
    localparam int A_RXCFG = 2;
    localparam int A_IRQ   = 3;
    localparam int A_TXLO  = 4;
    localparam int A_TXHI  = 5;
    localparam int A_RXLO  = 6;
    localparam int A_RXHI  = 7;

    localparam int N_DIR  = 2;
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
endpackage

// File: rtl/stamp_channel.sv
// One capture direction: snapshots the time value on a qualified event and
// locks until released. Assumes evt_i is already qualified by enable/filter.
module stamp_channel #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_i,
    input  logic            release_i,
    input  logic [TS_W-1:0] time_i,
    output logic            take_o,
    output logic            valid_o,
    output logic [TS_W-1:0] stamp_o
);
    // Capture only when unlocked and not being released this cycle.
    assign take_o = evt_i && !valid_o && !release_i;

    // Lock state and captured value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            stamp_o <= '0;
        end else if (release_i) begin
            valid_o <= 1'b0;
        end else if (take_o) begin
            valid_o <= 1'b1;
            stamp_o <= time_i;
        end
    end

    // R1
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (valid_o && stamp_o == $past(time_i)));

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !release_i) |=> (valid_o && $stable(stamp_o)));

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !valid_o);
endmodule

// File: rtl/rx_class_filter.sv
// Receive qualification: decides from the decoded class and message code
// whether a receive event is stamped under the selected mode.
module rx_class_filter
    import pkt_stamp_pkg::*;
#(
    parameter int MSG_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_i,
    input  logic [1:0]         class_i,
    input  logic [MSG_W-1:0]   msg_i,
    input  logic [1:0]         mode_i,
    input  logic [2*MSG_W-1:0] cfg_i,
    output logic               hit_o
);
    localparam int CW = 2 * MSG_W;

    logic [MSG_W-1:0] sync_code;
    logic [MSG_W-1:0] dreq_code;
    assign sync_code = cfg_i[MSG_W-1:0];
    assign dreq_code = cfg_i[CW-1:MSG_W];

    // Mode-dependent class/message match.
    always_comb begin
        unique case (rx_mode_e'(mode_i))
            RXM_V1_SYNC: hit_o = evt_i && (class_i == CLS_V1_UDP) && (msg_i == sync_code);
            RXM_V1_DREQ: hit_o = evt_i && (class_i == CLS_V1_UDP) && (msg_i == dreq_code);
            RXM_V2_EVT:  hit_o = evt_i && (class_i == CLS_V2_EVT);
            default:     hit_o = evt_i;
        endcase
    end

    // R5
    v2_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && mode_i == RXM_V2_EVT) |-> (class_i == CLS_V2_EVT));
endmodule

// File: rtl/stamp_regs.sv
// Register file: enables, filter mode/config, interrupt mask/cause, read mux
// and lock-release strobes. Assumes single-cycle reads with combinational data.
module stamp_regs
    import pkt_stamp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 3,
    parameter int MSG_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [N_DIR-1:0]   valid_i,
    input  logic [2*DW-1:0]    tx_stamp_i,
    input  logic [2*DW-1:0]    rx_stamp_i,
    input  logic               tx_take_i,
    output logic [DW-1:0]      rdata_o,
    output logic [N_DIR-1:0]   en_o,
    output logic [N_DIR-1:0]   release_o,
    output logic [1:0]         mode_o,
    output logic [2*MSG_W-1:0] cfg_o,
    output logic               irq_o
);
    localparam int CW = 2 * MSG_W;
    localparam logic [CW-1:0] CFG_RST = CW'(1) << MSG_W;

    logic mask_q;
    logic cause_q;
    logic wr_irq;

    assign wr_irq = wr_en_i && (int'(addr_i) == A_IRQ);
    assign release_o[DIR_TX] = rd_en_i && (int'(addr_i) == A_TXHI);
    assign release_o[DIR_RX] = rd_en_i && (int'(addr_i) == A_RXHI);
    assign irq_o = cause_q;

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            mode_o <= 2'd0;
            cfg_o  <= CFG_RST;
            mask_q <= 1'b0;
        end else if (wr_en_i) begin
            case (int'(addr_i))
                A_TXCTL: en_o[DIR_TX] <= wdata_i[0];
                A_RXCTL: begin
                    en_o[DIR_RX] <= wdata_i[0];
                    mode_o       <= wdata_i[3:2];
                end
                A_RXCFG: cfg_o  <= wdata_i[CW-1:0];
                A_IRQ:   mask_q <= wdata_i[1];
                default: ;
            endcase
        end
    end

    // Interrupt cause: set by masked transmit capture, write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= 1'b0;
        else if (tx_take_i && mask_q)
            cause_q <= 1'b1;
        else if (wr_irq && wdata_i[0])
            cause_q <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        rdata_o = '0;
        case (int'(addr_i))
            A_TXCTL: rdata_o[1:0] = {valid_i[DIR_TX], en_o[DIR_TX]};
            A_RXCTL: rdata_o[3:0] = {mode_o, valid_i[DIR_RX], en_o[DIR_RX]};
            A_RXCFG: rdata_o[CW-1:0] = cfg_o;
            A_IRQ:   rdata_o[1:0] = {mask_q, cause_q};
            A_TXLO:  rdata_o = tx_stamp_i[DW-1:0];
            A_TXHI:  rdata_o = tx_stamp_i[2*DW-1:DW];
            A_RXLO:  rdata_o = rx_stamp_i[DW-1:0];
            A_RXHI:  rdata_o = rx_stamp_i[2*DW-1:DW];
            default: rdata_o = '0;
        endcase
    end

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tx_take_i && mask_q));
endmodule

// File: rtl/pkt_stamp_latch.sv
// Top of the packet timestamp capture block: two locking capture channels,
// a receive filter and the register file. Assumes time_i is synchronous to clk.
module pkt_stamp_latch
    import pkt_stamp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 3,
    parameter int MSG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*DW-1:0]   time_i,
    input  logic              tx_evt_i,
    input  logic              rx_evt_i,
    input  logic [1:0]        rx_class_i,
    input  logic [MSG_W-1:0]  rx_msg_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              tx_valid_o,
    output logic              rx_valid_o,
    output logic              irq_o
);
    localparam int TS_W = 2 * DW;
    localparam int CW   = 2 * MSG_W;

    logic [N_DIR-1:0]  en;
    logic [N_DIR-1:0]  rel;
    logic [N_DIR-1:0]  qual;
    logic [N_DIR-1:0]  take;
    logic [N_DIR-1:0]  valid;
    logic [TS_W-1:0]   stamp [N_DIR];
    logic [1:0]        mode;
    logic [CW-1:0]     cfg;
    logic              rx_hit;

    rx_class_filter #(.MSG_W(MSG_W)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (rx_evt_i),
        .class_i (rx_class_i),
        .msg_i   (rx_msg_i),
        .mode_i  (mode),
        .cfg_i   (cfg),
        .hit_o   (rx_hit)
    );

    assign qual[DIR_TX] = tx_evt_i && en[DIR_TX];
    assign qual[DIR_RX] = rx_hit && en[DIR_RX];

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        stamp_channel #(.TS_W(TS_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (qual[d]),
            .release_i (rel[d]),
            .time_i    (time_i),
            .take_o    (take[d]),
            .valid_o   (valid[d]),
            .stamp_o   (stamp[d])
        );
    end

    stamp_regs #(.DW(DW), .AW(AW), .MSG_W(MSG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .valid_i    (valid),
        .tx_stamp_i (stamp[DIR_TX]),
        .rx_stamp_i (stamp[DIR_RX]),
        .tx_take_i  (take[DIR_TX]),
        .rdata_o    (rdata_o),
        .en_o       (en),
        .release_o  (rel),
        .mode_o     (mode),
        .cfg_o      (cfg),
        .irq_o      (irq_o)
    );

    assign tx_valid_o = valid[DIR_TX];
    assign rx_valid_o = valid[DIR_RX];

    // R4
    tx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[DIR_TX] && !tx_valid_o) |=> !tx_valid_o);
endmodule

// File: tb/pkt_stamp_latch_tb.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module pkt_stamp_latch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_i = '0;
    logic        tx_evt_i = 1'b0;
    logic        rx_evt_i = 1'b0;
    logic [1:0]  rx_class_i = '0;
    logic [3:0]  rx_msg_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        tx_valid_o, rx_valid_o, irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state
    bit          m_txen, m_rxen, m_mask, m_cause, m_txv, m_rxv;
    bit [1:0]    m_mode;
    bit [7:0]    m_cfg;
    bit [63:0]   m_txs, m_rxs;
    bit [63:0]   ev_time;

    pkt_stamp_latch dut_i (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .tx_evt_i(tx_evt_i),
        .rx_evt_i(rx_evt_i), .rx_class_i(rx_class_i), .rx_msg_i(rx_msg_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .tx_valid_o(tx_valid_o), .rx_valid_o(rx_valid_o),
        .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] model_rdata(input bit [2:0] a);
        case (a)
            3'd0: return {30'd0, m_txv, m_txen};
            3'd1: return {28'd0, m_mode, m_rxv, m_rxen};
            3'd2: return {24'd0, m_cfg};
            3'd3: return {30'd0, m_mask, m_cause};
            3'd4: return m_txs[31:0];
            3'd5: return m_txs[63:32];
            3'd6: return m_rxs[31:0];
            default: return m_rxs[63:32];
        endcase
    endfunction

    function automatic bit model_rx_hit();
        case (m_mode)
            2'd0: return rx_class_i == 2'd1 && rx_msg_i == m_cfg[3:0];
            2'd1: return rx_class_i == 2'd1 && rx_msg_i == m_cfg[7:4];
            2'd2: return rx_class_i == 2'd2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic model_reset();
        m_txen = 0; m_rxen = 0; m_mask = 0; m_cause = 0; m_txv = 0; m_rxv = 0;
        m_mode = 0; m_cfg = 8'h10; m_txs = 0; m_rxs = 0;
    endtask

    task automatic model_update();
        bit rel_tx, rel_rx, take_tx, take_rx;
        if (!rst_n) begin
            model_reset();
            return;
        end
        rel_tx = rd_en_i && addr_i == 3'd5;
        rel_rx = rd_en_i && addr_i == 3'd7;
        take_tx = tx_evt_i && m_txen && !m_txv && !rel_tx;
        take_rx = rx_evt_i && m_rxen && model_rx_hit() && !m_rxv && !rel_rx;
        if (take_tx && m_mask) m_cause = 1;
        else if (wr_en_i && addr_i == 3'd3 && wdata_i[0]) m_cause = 0;
        if (wr_en_i) begin
            case (addr_i)
                3'd0: m_txen = wdata_i[0];
                3'd1: begin m_rxen = wdata_i[0]; m_mode = wdata_i[3:2]; end
                3'd2: m_cfg = wdata_i[7:0];
                3'd3: m_mask = wdata_i[1];
                default: ;
            endcase
        end
        if (rel_tx) m_txv = 0;
        else if (take_tx) begin m_txv = 1; m_txs = time_i; end
        if (rel_rx) m_rxv = 0;
        else if (take_rx) begin m_rxv = 1; m_rxs = time_i; end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R1 R2 tx_valid per-cycle", tx_valid_o, m_txv);
        chk("R1 R2 rx_valid per-cycle", rx_valid_o, m_rxv);
        chk("R6 irq per-cycle", irq_o, m_cause);
        wr_en_i = 0; rd_en_i = 0; tx_evt_i = 0; rx_evt_i = 0;
        cyc++;
        time_i = {32'hA500_0000 + 32'(cyc), 32'h1000_0000 + 32'(cyc * 3)};
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        wr_en_i = 1; addr_i = a; wdata_i = d;
        step();
    endtask

    task automatic rd(input bit [2:0] a, input bit [31:0] exp, input string tag);
        addr_i = a; rd_en_i = 1;
        #1;
        chk(tag, rdata_o, exp);
        chk({tag, " model"}, rdata_o, model_rdata(a));
        step();
    endtask

    task automatic rx_event(input bit [1:0] cls, input bit [3:0] msg);
        rx_evt_i = 1; rx_class_i = cls; rx_msg_i = msg;
        ev_time = time_i;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        step(); step();
        rst_n = 1;
        step();
        // R9 reset values
        rd(3'd0, 32'h0, "R9 txctl reset");
        rd(3'd1, 32'h0, "R9 rxctl reset");
        rd(3'd2, 32'h10, "R9 rxcfg reset");
        rd(3'd3, 32'h0, "R9 irq reset");
        rd(3'd5, 32'h0, "R9 txhi reset");
        rd(3'd7, 32'h0, "R9 rxhi reset");

        // R4: disabled transmit ignores events
        tx_evt_i = 1; step();
        chk("R4 tx disabled", tx_valid_o, 0);

        // R1 / R6: masked capture
        wr(3'd0, 32'h1);
        wr(3'd3, 32'h2);
        tx_evt_i = 1; ev_time = time_i; step();
        chk("R1 tx valid", tx_valid_o, 1);
        chk("R6 irq raised", irq_o, 1);
        // R2: second event ignored
        tx_evt_i = 1; step();
        rd(3'd4, ev_time[31:0], "R2 R1 tx low kept");
        chk("R3 low read keeps valid", tx_valid_o, 1);
        // R6: clear collides with nothing, then clears
        wr(3'd3, 32'h3);
        chk("R6 irq cleared", irq_o, 0);
        rd(3'd5, ev_time[63:32], "R1 tx high");
        chk("R3 high read releases", tx_valid_o, 0);

        // R6: capture in same cycle as clear keeps the cause
        tx_evt_i = 1; wr(3'd3, 32'h3);
        chk("R6 set beats clear", irq_o, 1);
        rd(3'd5, model_rdata(3'd5), "R3 tx release");
        wr(3'd3, 32'h1);
        chk("R6 unmask clear", irq_o, 0);
        tx_evt_i = 1; step();
        chk("R6 no cause when masked", irq_o, 0);
        rd(3'd5, model_rdata(3'd5), "R3 tx release 2");

        // R5 mode 0: sync code 0
        wr(3'd1, 32'h1);
        rx_event(2'd1, 4'd1);
        chk("R5 mode0 rejects msg1", rx_valid_o, 0);
        rx_event(2'd1, 4'd0);
        chk("R5 mode0 takes sync", rx_valid_o, 1);
        rd(3'd6, ev_time[31:0], "R5 R1 rx low");
        rd(3'd7, ev_time[63:32], "R5 rx high");
        // R5 mode 1 with reconfigured codes
        wr(3'd2, 32'h3A);
        wr(3'd1, 32'h5);
        rx_event(2'd1, 4'hA);
        chk("R5 mode1 rejects sync code", rx_valid_o, 0);
        rx_event(2'd2, 4'h3);
        chk("R5 mode1 rejects class2", rx_valid_o, 0);
        rx_event(2'd1, 4'h3);
        chk("R5 mode1 takes dreq", rx_valid_o, 1);
        rd(3'd7, ev_time[63:32], "R5 mode1 high");
        // R5 mode 2
        wr(3'd1, 32'h9);
        rx_event(2'd1, 4'h3);
        chk("R5 mode2 rejects v1", rx_valid_o, 0);
        rx_event(2'd3, 4'h0);
        chk("R5 mode2 rejects general", rx_valid_o, 0);
        rx_event(2'd2, 4'h7);
        chk("R5 mode2 takes v2 event", rx_valid_o, 1);
        rd(3'd7, ev_time[63:32], "R5 mode2 high");
        // R5 mode 3
        wr(3'd1, 32'hD);
        rx_event(2'd0, 4'hF);
        chk("R5 mode3 takes any", rx_valid_o, 1);

        // R7: control writes keep the pending capture
        wr(3'd1, 32'h4);
        wr(3'd1, 32'h0);
        chk("R7 valid kept", rx_valid_o, 1);
        rd(3'd6, ev_time[31:0], "R7 stamp kept");
        wr(3'd1, 32'hD);

        // R8: event in the releasing cycle is dropped
        rx_evt_i = 1; rx_class_i = 2'd0;
        rd(3'd7, ev_time[63:32], "R8 release read");
        chk("R8 not captured", rx_valid_o, 0);
        rx_event(2'd0, 4'h0);
        chk("R8 rearmed", rx_valid_o, 1);
        rd(3'd6, ev_time[31:0], "R8 new stamp");

        // R4: receive disabled
        rd(3'd7, model_rdata(3'd7), "R3 rx release");
        wr(3'd1, 32'hC);
        rx_event(2'd0, 4'h0);
        chk("R4 rx disabled", rx_valid_o, 0);
        step();

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule